// File: doc/BRIEF.md
# Byte-Lane Data Word Packer

This block connects a word-wide data register to a byte-serial two-wire bus engine. In the transmit direction, software writes 32-bit words into the register and the packer hands them to the engine one byte at a time, lane 0 (bits 7:0) first, then lanes 1, 2 and 3. Software places the address byte (7-bit address shifted left by one, with the read/write bit in bit 0) in lane 0 of the first word, followed by up to three payload bytes. In the receive direction, the engine delivers bytes one at a time and the packer places them into a word starting from lane 0. Software then reads that word from the register.

Each command is started with a one-cycle pulse that carries a direction and a byte count. The byte count is the number of bytes that cross the bus, and on transmit it includes the address byte. A sticky request flag tells software that the register needs attention: either a fresh word must be written, or a filled word is waiting to be read. Software clears the flag with a write-one-to-clear pulse. While a request is not yet serviced, the packer stalls the engine. On transmit it withholds `tx_valid`, and on receive it withholds `rx_ready`.

Top module: `byte_lane_packer`

## Requirements
- R1: On transmit, the bytes of each written word go to the engine in lane order: bits 7:0 first, then 15:8, 23:16 and 31:24. One byte moves per cycle in which `tx_valid` and `tx_ready` are both high.
- R2: The first byte sent after `cmd_start` is lane 0 of the first word written for that command. This is the address byte.
- R3: When the transmit count is not a multiple of four, the final word is consumed from lane 0 upward, and its upper lanes are never sent. After the last byte, `tx_valid` is low and no new request is raised.
- R4: On receive, the k-th byte of a word (k = 0..3) lands in bits 8k+7:8k of `reg_rd_data`. A word is complete after four bytes.
- R5: On receive, when the count is not a multiple of four, the final word is complete after the last byte, and its unfilled upper lanes read as zero.
- R6: `req_flag` rises one cycle after any of these events: a transmit `cmd_start` with a non-zero count; the consumption of the last byte of a transmit word while bytes remain; the arrival of the byte that completes a receive word.
- R7: A one-cycle `req_clr` pulse drops `req_flag` on the next cycle. If a set event occurs in the same cycle, the flag stays high. Otherwise the flag holds its value.
- R8: `tx_valid` stays low until a word has been written for the current transmit position. `rx_ready` stays low while a completed receive word has not yet been read with `reg_rd_en`.
- R9: A `cmd_start` during an unfinished command discards any held word and restarts the lane pointer at 0. The next byte sent is lane 0 of the next written word.
- R10: After a synchronous reset (`rst_n` low at a clock edge), `req_flag`, `tx_valid` and `rx_ready` are 0, and `reg_rd_data` is zero.
- R11: A `reg_wr_en` pulse while a transmit word is still held is ignored. The bytes sent afterwards come from the earlier word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_start | input | 1 | One-cycle pulse that starts a command |
| cmd_rx | input | 1 | Command direction: 1 receive, 0 transmit |
| cmd_count | input | CNT_W | Bytes on the bus for the command (transmit count includes the address byte) |
| reg_wr_en | input | 1 | Software write of a transmit word |
| reg_wr_data | input | 8*WORD_BYTES | Transmit word, lane 0 is sent first |
| reg_rd_en | input | 1 | Software read of the filled receive word |
| reg_rd_data | output | 8*WORD_BYTES | Receive word being assembled or held |
| req_clr | input | 1 | Write-one-to-clear pulse for the request flag |
| req_flag | output | 1 | Sticky request: a word must be written or read |
| tx_valid | output | 1 | A transmit byte is available to the engine |
| tx_ready | input | 1 | The engine takes the transmit byte |
| tx_byte | output | 8 | Current transmit byte |
| rx_valid | input | 1 | The engine offers a received byte |
| rx_ready | output | 1 | The packer can accept a received byte |
| rx_byte | input | 8 | Received byte |

## Verification
The transmit byte outputs and `rx_ready` are combinational from state, so they are due in the same cycle that the state allows them. The request flag and a held word appear one clock edge after the event that causes them. The bench drives every input on the falling edge and samples 1 ns later, so each registered result is compared in the half-cycle after the edge that loads it. Each transmit byte is compared in the same half-cycle as the handshake that moves it.

// File: rtl/bl_pkg.sv
// Shared types for the byte-lane packer.
// Assumes nothing beyond IEEE 1800-2017 packages.
package bl_pkg;
    // Direction of the active command
    typedef enum logic {
        DIR_TX = 1'b0,
        DIR_RX = 1'b1
    } bl_dir_e;
endpackage

// File: rtl/bl_lane_ctrl.sv
// Lane pointer and byte countdown for one command.
// Does: tracks which lane of the current word is next and how many bytes
// remain; flags the last lane of a word and the last byte of the command.
// Assumes: WORD_BYTES is a power of two, at least 2; step only while active.
module bl_lane_ctrl #(
    parameter int WORD_BYTES = 4,
    parameter int CNT_W      = 16,
    localparam int LANE_W    = $clog2(WORD_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CNT_W-1:0]  count,
    input  logic              step,
    output logic [LANE_W-1:0] lane,
    output logic              word_end,
    output logic              last_byte,
    output logic              active
);
    localparam logic [LANE_W-1:0] LANE_LAST = LANE_W'(WORD_BYTES - 1);

    logic [LANE_W-1:0] lane_q;
    logic [CNT_W-1:0]  left_q;

    // Lane pointer and remaining-byte counter; start restarts both
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lane_q <= '0;
            left_q <= '0;
        end else if (start) begin
            lane_q <= '0;
            left_q <= count;
        end else if (step && active) begin
            lane_q <= word_end ? '0 : lane_q + 1'b1;
            left_q <= left_q - 1'b1;
        end
    end

    assign lane      = lane_q;
    assign active    = (left_q != '0);
    assign last_byte = (left_q == CNT_W'(1));
    assign word_end  = (lane_q == LANE_LAST) || last_byte;

    AST_START_LANE0: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (lane_q == '0));                                         // R9
    AST_WORD_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && active && word_end && !start) |=> (lane_q == '0));        // R3
endmodule

// File: rtl/bl_req_flag.sv
// Sticky request flag with write-one-to-clear.
// Does: sets on any request event, clears on a clear pulse; set wins.
// Assumes: set and clr are single-cycle qualified strobes.
module bl_req_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic req
);
    logic req_q;

    // Flag register: set has priority over clear
    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= 1'b0;
        else if (set) req_q <= 1'b1;
        else if (clr) req_q <= 1'b0;
    end

    assign req = req_q;

    AST_REQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> req_q);                                                    // R6
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_q && !clr) |=> req_q);                                        // R7
    AST_REQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !set) |=> !req_q);                                         // R7
endmodule

// File: rtl/bl_tx_unpack.sv
// Transmit side: holds one written word and presents its lanes as bytes.
// Does: loads a word when empty, offers lane[lane] to the engine, empties
// after the last lane of a word or the last byte of the command.
// Assumes: lane comes from bl_lane_ctrl and advances on each take.
module bl_tx_unpack #(
    parameter int WORD_BYTES = 4,
    localparam int LANE_W    = $clog2(WORD_BYTES),
    localparam int WORD_W    = 8 * WORD_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              en,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [LANE_W-1:0] lane,
    input  logic              word_end,
    input  logic              ready,
    output logic              valid,
    output logic [7:0]        byte_out,
    output logic              take
);
    logic [WORD_W-1:0] word_q;
    logic              full_q;
    logic [7:0]        lane_bytes [WORD_BYTES];

    // Word holding register: load when empty, drop when its bytes are used
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
            full_q <= 1'b0;
        end else if (start) begin
            full_q <= 1'b0;
        end else if (take && word_end) begin
            full_q <= 1'b0;
        end else if (wr_en && en && !full_q) begin
            word_q <= wr_data;
            full_q <= 1'b1;
        end
    end

    // Split the held word into byte lanes
    for (genvar g = 0; g < WORD_BYTES; g++) begin : g_lane
        assign lane_bytes[g] = word_q[g*8 +: 8];
    end

    assign valid    = full_q && en;
    assign take     = valid && ready;
    assign byte_out = lane_bytes[lane];

    AST_TX_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (take && word_end && !start) |=> !valid);                          // R8
    AST_TX_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (full_q && wr_en && !take && !start) |=> $stable(word_q));         // R11
endmodule

// File: rtl/bl_rx_pack.sv
// Receive side: fills a word lane by lane and holds it until read.
// Does: writes each accepted byte into the current lane, marks the word
// complete at the word or command end, zeroes all lanes after a read.
// Assumes: lane comes from bl_lane_ctrl and advances on each accept.
module bl_rx_pack #(
    parameter int WORD_BYTES = 4,
    localparam int LANE_W    = $clog2(WORD_BYTES),
    localparam int WORD_W    = 8 * WORD_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              en,
    input  logic              in_valid,
    input  logic [7:0]        in_byte,
    input  logic [LANE_W-1:0] lane,
    input  logic              word_end,
    input  logic              rd_en,
    output logic              in_ready,
    output logic              accept,
    output logic [WORD_W-1:0] word_out
);
    logic hold_q;
    logic flush;

    assign in_ready = en && !hold_q;
    assign accept   = in_valid && in_ready;
    assign flush    = start || (rd_en && hold_q);

    // Completion flag: set by the closing byte, cleared by read or start
    always_ff @(posedge clk) begin
        if (!rst_n) hold_q <= 1'b0;
        else if (flush) hold_q <= 1'b0;
        else if (accept && word_end) hold_q <= 1'b1;
    end

    // One byte register per lane; unfilled lanes stay zero
    for (genvar g = 0; g < WORD_BYTES; g++) begin : g_lane
        logic [7:0] byte_q;
        always_ff @(posedge clk) begin
            if (!rst_n) byte_q <= '0;
            else if (flush) byte_q <= '0;
            else if (accept && (lane == LANE_W'(g))) byte_q <= in_byte;
        end
        assign word_out[g*8 +: 8] = byte_q;
    end

    AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_q && !rd_en && !start) |=> (hold_q && !in_ready));           // R8
    AST_RX_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && hold_q) |=> (word_out == '0));                           // R5
endmodule

// File: rtl/byte_lane_packer.sv
// Byte-lane packer between a word data register and a byte-serial engine.
// Does: unpacks transmit words lane 0 first, packs received bytes lane 0
// first, raises a sticky request whenever the register needs service and
// stalls the engine until it gets it.
// Assumes: cmd_start is a single-cycle pulse; software builds the address
// byte into lane 0 of the first transmit word.
module byte_lane_packer #(
    parameter int WORD_BYTES = 4,
    parameter int CNT_W      = 16,
    localparam int LANE_W    = $clog2(WORD_BYTES),
    localparam int WORD_W    = 8 * WORD_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_start,
    input  logic              cmd_rx,
    input  logic [CNT_W-1:0]  cmd_count,
    input  logic              reg_wr_en,
    input  logic [WORD_W-1:0] reg_wr_data,
    input  logic              reg_rd_en,
    output logic [WORD_W-1:0] reg_rd_data,
    input  logic              req_clr,
    output logic              req_flag,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [7:0]        tx_byte,
    input  logic              rx_valid,
    output logic              rx_ready,
    input  logic [7:0]        rx_byte
);
    import bl_pkg::*;

    bl_dir_e           dir_q;
    logic [LANE_W-1:0] lane;
    logic              word_end, last_byte, active;
    logic              tx_en, rx_en, tx_take, rx_accept, step, req_set;

    // Latch the command direction at each start
    always_ff @(posedge clk) begin
        if (!rst_n) dir_q <= DIR_TX;
        else if (cmd_start) dir_q <= cmd_rx ? DIR_RX : DIR_TX;
    end

    assign tx_en = active && (dir_q == DIR_TX);
    assign rx_en = active && (dir_q == DIR_RX);
    assign step  = tx_take || rx_accept;

    // Request events: first transmit word, next transmit word, full receive word
    assign req_set = (cmd_start && !cmd_rx && (cmd_count != '0))
                   || (tx_take && word_end && !last_byte && !cmd_start)
                   || (rx_accept && word_end && !cmd_start);

    bl_lane_ctrl #(.WORD_BYTES(WORD_BYTES), .CNT_W(CNT_W)) u_lane (
        .clk(clk), .rst_n(rst_n), .start(cmd_start), .count(cmd_count),
        .step(step), .lane(lane), .word_end(word_end),
        .last_byte(last_byte), .active(active)
    );

    bl_tx_unpack #(.WORD_BYTES(WORD_BYTES)) u_tx (
        .clk(clk), .rst_n(rst_n), .start(cmd_start), .en(tx_en),
        .wr_en(reg_wr_en), .wr_data(reg_wr_data), .lane(lane),
        .word_end(word_end), .ready(tx_ready), .valid(tx_valid),
        .byte_out(tx_byte), .take(tx_take)
    );

    bl_rx_pack #(.WORD_BYTES(WORD_BYTES)) u_rx (
        .clk(clk), .rst_n(rst_n), .start(cmd_start), .en(rx_en),
        .in_valid(rx_valid), .in_byte(rx_byte), .lane(lane),
        .word_end(word_end), .rd_en(reg_rd_en), .in_ready(rx_ready),
        .accept(rx_accept), .word_out(reg_rd_data)
    );

    bl_req_flag u_req (
        .clk(clk), .rst_n(rst_n), .set(req_set), .clr(req_clr), .req(req_flag)
    );

    AST_ONE_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_valid && rx_ready));                                          // R8
    AST_TX_FIRST_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_start && !cmd_rx && (cmd_count != '0)) |=> (req_flag && !tx_valid)); // R6
endmodule

// File: tb/sim_byte_lane_packer.sv
module sim_byte_lane_packer;
    localparam int PERIOD = 10;
    localparam int NV     = 7;
    localparam bit          VEC_RX [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1};
    localparam int          VEC_N  [NV] = '{1, 3, 5, 8, 2, 4, 7};
    localparam logic [63:0] VEC_D  [NV] = '{
        64'h0000_0000_0000_00A0, 64'h0000_0000_0033_22A1,
        64'h0000_0055_4433_22A4, 64'h8877_6655_4433_22A6,
        64'h0000_0000_0000_B2C1, 64'h0000_0000_D4C3_B2A1,
        64'h0007_0605_0403_0201};

    logic clk = 0, rst_n = 0;
    logic cmd_start = 0, cmd_rx = 0;
    logic [15:0] cmd_count = 0;
    logic reg_wr_en = 0, reg_rd_en = 0, req_clr = 0;
    logic [31:0] reg_wr_data = 0, reg_rd_data;
    logic req_flag, tx_valid, tx_ready = 0, rx_valid = 0, rx_ready;
    logic [7:0] tx_byte, rx_byte = 0;
    int checks = 0, fails = 0;
    bit done = 0;

    always #(PERIOD/2) clk = ~clk;

    byte_lane_packer u0 (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_rx(cmd_rx),
        .cmd_count(cmd_count), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
        .reg_rd_en(reg_rd_en), .reg_rd_data(reg_rd_data), .req_clr(req_clr),
        .req_flag(req_flag), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .tx_byte(tx_byte), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .rx_byte(rx_byte)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic start_cmd(input logic rx, input int n);
        @(negedge clk);
        cmd_start = 1; cmd_rx = rx; cmd_count = 16'(n);
        @(negedge clk);
        cmd_start = 0;
    endtask

    // Transmit n bytes: word w carries bytes 4w..4w+3, unused lanes filled with EE
    task automatic run_tx(input int n, input logic [63:0] d);
        start_cmd(1'b0, n);
        for (int w = 0; w < (n + 3) / 4; w++) begin
            logic [31:0] word;
            #1;
            chk("R6 request before word", 32'(req_flag), 1);
            chk("R8 stall without word", 32'(tx_valid), 0);
            for (int j = 0; j < 4; j++)
                word[8*j +: 8] = (4*w + j < n) ? d[8*(4*w+j) +: 8] : 8'hEE;
            reg_wr_en = 1; reg_wr_data = word; req_clr = 1;
            @(negedge clk);
            reg_wr_en = 0; req_clr = 0;
            for (int j = 0; j < 4 && 4*w + j < n; j++) begin
                tx_ready = 1;
                #1;
                chk("R1 byte valid", 32'(tx_valid), 1);
                chk((w == 0 && j == 0) ? "R2 address first" : "R1 lane order",
                    32'(tx_byte), 32'(d[8*(4*w+j) +: 8]));
                @(negedge clk);
            end
            tx_ready = 0;
        end
        #1;
        chk("R3 no byte after last", 32'(tx_valid), 0);
        chk("R3 no request after last", 32'(req_flag), 0);
    endtask

    // Receive n bytes and read each completed word
    task automatic run_rx(input int n, input logic [63:0] d);
        start_cmd(1'b1, n);
        for (int i = 0; i < n; i++) begin
            #1;
            chk("R8 ready for byte", 32'(rx_ready), 1);
            rx_valid = 1; rx_byte = d[8*i +: 8];
            @(negedge clk);
            rx_valid = 0;
            if (i % 4 == 3 || i == n - 1) begin
                logic [31:0] exp;
                int w;
                w = i / 4;
                for (int j = 0; j < 4; j++)
                    exp[8*j +: 8] = (4*w + j < n) ? d[8*(4*w+j) +: 8] : 8'h00;
                #1;
                chk("R6 request on full word", 32'(req_flag), 1);
                chk("R8 stall until read", 32'(rx_ready), 0);
                chk((i % 4 == 3) ? "R4 packed word" : "R5 partial word zero upper",
                    reg_rd_data, exp);
                reg_rd_en = 1; req_clr = 1;
                @(negedge clk);
                reg_rd_en = 0; req_clr = 0;
            end
        end
    endtask

    initial begin
        #1;
        @(negedge clk); @(negedge clk);
        rst_n = 1;
        #1;
        chk("R10 reset req", 32'(req_flag), 0);
        chk("R10 reset tx_valid", 32'(tx_valid), 0);
        chk("R10 reset rx_ready", 32'(rx_ready), 0);
        chk("R10 reset rd_data", reg_rd_data, 0);

        for (int v = 0; v < NV; v++) begin
            if (VEC_RX[v]) run_rx(VEC_N[v], VEC_D[v]);
            else run_tx(VEC_N[v], VEC_D[v]);
        end

        // R11: second write while a word is held is ignored
        start_cmd(1'b0, 2);
        reg_wr_en = 1; reg_wr_data = 32'hEEEE_5A11; req_clr = 1;
        @(negedge clk);
        reg_wr_data = 32'h0000_7766; req_clr = 0;
        @(negedge clk);
        reg_wr_en = 0; tx_ready = 1;
        #1 chk("R11 ignored write lane0", 32'(tx_byte), 32'h11);
        @(negedge clk);
        #1 chk("R11 ignored write lane1", 32'(tx_byte), 32'h5A);
        @(negedge clk);
        tx_ready = 0;

        // R7: clear in the same cycle as a set keeps the flag
        start_cmd(1'b0, 6);
        reg_wr_en = 1; reg_wr_data = 32'h4433_2211; req_clr = 1;
        @(negedge clk);
        reg_wr_en = 0; req_clr = 0; tx_ready = 1;
        @(negedge clk); @(negedge clk); @(negedge clk);
        req_clr = 1;
        @(negedge clk);
        tx_ready = 0; req_clr = 0;
        #1 chk("R7 set wins over clear", 32'(req_flag), 1);
        @(negedge clk);
        #1 chk("R7 flag holds without clear", 32'(req_flag), 1);
        req_clr = 1;
        @(negedge clk);
        req_clr = 0;
        #1 chk("R7 clear drops flag", 32'(req_flag), 0);
        reg_wr_en = 1; reg_wr_data = 32'h0000_6655;
        @(negedge clk);
        reg_wr_en = 0; tx_ready = 1;
        #1 chk("R1 second word lane0", 32'(tx_byte), 32'h55);
        @(negedge clk); @(negedge clk);
        tx_ready = 0;

        // R9: restart mid-command resets the lane pointer
        start_cmd(1'b0, 4);
        reg_wr_en = 1; reg_wr_data = 32'h4433_2211; req_clr = 1;
        @(negedge clk);
        reg_wr_en = 0; req_clr = 0; tx_ready = 1;
        @(negedge clk); @(negedge clk);
        tx_ready = 0;
        start_cmd(1'b0, 2);
        #1 chk("R9 held word discarded", 32'(tx_valid), 0);
        reg_wr_en = 1; reg_wr_data = 32'hDDCC_BBAA; req_clr = 1;
        @(negedge clk);
        reg_wr_en = 0; req_clr = 0; tx_ready = 1;
        #1 chk("R9 lane 0 after restart", 32'(tx_byte), 32'hAA);
        @(negedge clk);
        #1 chk("R9 lane 1 after restart", 32'(tx_byte), 32'hBB);
        @(negedge clk);
        tx_ready = 0;

        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        #(PERIOD * 50000);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule